// File: doc/BRIEF.md
# Column-Parallel Pupil Moment Accumulator

This block gathers the three image moments needed to locate a dark pupil in an eye image. It has one lane for every pixel column. While the frame is read out row by row, each lane receives that row's pupil flag for its column. A flag of 1 means the pixel is dark enough to count as pupil. Each lane adds the flag into three running sums:
- the number of pupil pixels in the column,
- that count weighted by the column's fixed X position,
- the count weighted by the row index of each contributing row.

All lanes update in the same clock cycle. The products are formed by gating the coordinate bits with the flag, so no multiplier is needed. Each sum is a ripple-carry chain of identical one-bit cells.

Once every row of the frame has been taken in, the block holds its sums. A downstream reducer then walks a one-hot column select across the lanes and reads each lane's three sums from a shared result bus. The bus is built as an AND-OR network: each lane gates its sums with its own enable, and the gated values are ORed together. A frame-start pulse clears every lane and begins the next frame.

A small sequencer tracks the frame with three states:
- `PH_IDLE`: after reset, before any frame has begun.
- `PH_ROWS`: taking in rows.
- `PH_HOLD`: sums frozen and readable.

Its transitions are:
- start (`PH_IDLE`→`PH_ROWS` on frame_start),
- restart (`PH_ROWS`→`PH_ROWS` on frame_start),
- finish (`PH_ROWS`→`PH_HOLD` when the last row is accepted),
- rearm (`PH_HOLD`→`PH_ROWS` on frame_start).

Top module: `pupil_moment_acc`

## Requirements
- R1: After reset every sum is zero, the sequencer is in `PH_IDLE`, rd_valid is 0 and all three read outputs are 0.
- R2: A frame_start pulse clears all three sums in every column at the next clock edge and enters `PH_ROWS` from any state. A row offered in the same cycle as frame_start is dropped.
- R3: A row is accepted when row_valid is 1 in `PH_ROWS` and frame_start is 0. For an accepted row, the column with index x (the lane fed by pix_flags bit x) adds its flag to its area sum, x·flag to its X-moment sum, and row_idx·flag to its Y-moment sum.
- R4: In a cycle where no row is accepted (row_valid low, or no frame in progress), no sum changes.
- R5: After NUM_ROWS accepted rows the sequencer enters `PH_HOLD`. It stays there, ignoring row_valid, until the next frame_start.
- R6: In `PH_HOLD`, with col_sel one-hot at bit x, rd_area, rd_xmom and rd_ymom show column x's sums in the same cycle, and rd_valid is 1. At most one col_sel bit may be set.
- R7: When col_sel is all zero, or the sequencer is not in `PH_HOLD`, rd_valid is 0 and all three read outputs are 0.
- R8: An all-ones frame does not overflow. Column x reads area NUM_ROWS, X-moment x·NUM_ROWS, and Y-moment NUM_ROWS·(NUM_ROWS−1)/2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| frame_start | input | 1 | Clears all sums and begins a frame |
| row_valid | input | 1 | A row of flags is offered this cycle |
| row_idx | input | YW | Row index used as the Y weight |
| pix_flags | input | NUM_COLS | Pupil flag per column, bit x for column x |
| col_sel | input | NUM_COLS | One-hot column read enable |
| rd_valid | output | 1 | Read bus carries a selected column's sums |
| rd_area | output | AW | Selected column's pixel count |
| rd_xmom | output | XMW | Selected column's X-weighted sum |
| rd_ymom | output | YMW | Selected column's Y-weighted sum |

## Verification
The hardest situation to reach from the ports is a frame_start that lands in the same cycle as a valid row in the middle of a frame. The restart must win, so the row is lost and no stale partial sums leak into the next frame. The bench builds a partial frame of all-ones rows, then offers one more all-ones row together with frame_start. It then feeds a complete frame with reversed row indices. Every lane is read afterwards: any leftover count from the abandoned frame would show up as an excess in the area and moment sums. The all-ones frame separately drives every carry chain to its top value.

// File: rtl/pma_pkg.sv
package pma_pkg;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_ROWS = 2'd1,
        PH_HOLD = 2'd2
    } pma_phase_e;

    // Bits needed to hold the value maxv (at least one).
    function automatic int bits_for(input int maxv);
        return (maxv < 2) ? 1 : $clog2(maxv + 1);
    endfunction

endpackage

// File: rtl/pma_bit_cell.sv
module pma_bit_cell (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic en,
    input  logic b,
    input  logic ci,
    input  logic oe,
    output logic q,
    output logic co,
    output logic drv
);

    // Full adder around the stored bit.
    assign co  = (q & b) | (ci & (q ^ b));
    // Bus driver: passes the stored bit only while enabled.
    assign drv = q & oe;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= 1'b0;
        end else if (clr) begin
            q <= 1'b0;
        end else if (en) begin
            q <= q ^ b ^ ci;
        end
    end

endmodule

// File: rtl/pma_ripple_acc.sv
module pma_ripple_acc #(
    parameter int W  = 4,
    parameter int BW = 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          en,
    input  logic          oe,
    input  logic [BW-1:0] addend,
    output logic [W-1:0]  sum,
    output logic [W-1:0]  drv
);

    logic [W-1:0] b_ext;
    logic [W:0]   carry;

    assign b_ext    = W'(addend);
    assign carry[0] = 1'b0;

    for (genvar i = 0; i < W; i++) begin : g_cell
        pma_bit_cell u_cell (
            .clk  (clk),
            .rst_n(rst_n),
            .clr  (clr),
            .en   (en),
            .b    (b_ext[i]),
            .ci   (carry[i]),
            .oe   (oe),
            .q    (sum[i]),
            .co   (carry[i+1]),
            .drv  (drv[i])
        );
    end

    // R8
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en && !clr) |-> !carry[W]);

    // R4
    hold_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!en && !clr) |=> $stable(sum));

endmodule

// File: rtl/pma_column.sv
module pma_column #(
    parameter int NY   = 8,
    parameter int XPOS = 0,
    parameter int XW   = 3,
    parameter int YW   = 3,
    parameter int AW   = 4,
    parameter int XMW  = 6,
    parameter int YMW  = 5
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           clr,
    input  logic           en,
    input  logic           oe,
    input  logic           flag,
    input  logic [YW-1:0]  row_idx,
    output logic [AW-1:0]  area_drv,
    output logic [XMW-1:0] xmom_drv,
    output logic [YMW-1:0] ymom_drv
);

    localparam logic [XW-1:0] XCOORD = XW'(XPOS);

    logic [XW-1:0]  x_term;
    logic [YW-1:0]  y_term;
    logic [AW-1:0]  area_sum;
    logic [XMW-1:0] xmom_sum;
    logic [YMW-1:0] ymom_sum;

    // Products formed by gating the coordinate bits with the flag.
    assign x_term = XCOORD & {XW{flag}};
    assign y_term = row_idx & {YW{flag}};

    pma_ripple_acc #(.W(AW), .BW(1)) u_area (
        .clk(clk), .rst_n(rst_n), .clr(clr), .en(en), .oe(oe),
        .addend(flag), .sum(area_sum), .drv(area_drv)
    );

    pma_ripple_acc #(.W(XMW), .BW(XW)) u_xmom (
        .clk(clk), .rst_n(rst_n), .clr(clr), .en(en), .oe(oe),
        .addend(x_term), .sum(xmom_sum), .drv(xmom_drv)
    );

    pma_ripple_acc #(.W(YMW), .BW(YW)) u_ymom (
        .clk(clk), .rst_n(rst_n), .clr(clr), .en(en), .oe(oe),
        .addend(y_term), .sum(ymom_sum), .drv(ymom_drv)
    );

    // R3
    xmom_ratio_chk: assert property (@(posedge clk) disable iff (!rst_n)
        int'(xmom_sum) == XPOS * int'(area_sum));

    // R5
    area_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        int'(area_sum) <= NY);

    // R2
    clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (area_sum == '0 && xmom_sum == '0 && ymom_sum == '0));

endmodule

// File: rtl/pma_seq.sv
module pma_seq
    import pma_pkg::*;
#(
    parameter int NY = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic frame_start,
    input  logic row_valid,
    output logic acc_en,
    output logic clr,
    output logic rd_phase
);

    localparam int CW = bits_for(NY);

    pma_phase_e    state_q, state_d;
    logic [CW-1:0] cnt_q, cnt_d;
    logic          last_row;

    assign last_row = (cnt_q == CW'(NY - 1));

    // State and row-count register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= PH_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    // Next-state logic.
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            PH_IDLE: begin
                if (frame_start) begin
                    state_d = PH_ROWS;
                    cnt_d   = '0;
                end
            end
            PH_ROWS: begin
                if (frame_start) begin
                    state_d = PH_ROWS;
                    cnt_d   = '0;
                end else if (row_valid) begin
                    cnt_d = cnt_q + 1'b1;
                    if (last_row) begin
                        state_d = PH_HOLD;
                    end
                end
            end
            PH_HOLD: begin
                if (frame_start) begin
                    state_d = PH_ROWS;
                    cnt_d   = '0;
                end
            end
            default: begin
                state_d = PH_IDLE;
                cnt_d   = '0;
            end
        endcase
    end

    // Outputs.
    always_comb begin
        clr      = frame_start;
        acc_en   = 1'b0;
        rd_phase = 1'b0;
        unique case (state_q)
            PH_IDLE: ;
            PH_ROWS: acc_en   = row_valid && !frame_start;
            PH_HOLD: rd_phase = 1'b1;
            default: ;
        endcase
    end

    // R2
    restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        frame_start |=> (state_q == PH_ROWS && cnt_q == '0));

    // R5
    hold_stays_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == PH_HOLD && !frame_start) |=> state_q == PH_HOLD);

    // R5
    row_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == PH_ROWS) |-> (int'(cnt_q) < NY));

endmodule

// File: rtl/pupil_moment_acc.sv
module pupil_moment_acc
    import pma_pkg::*;
#(
    parameter  int NUM_COLS = 8,
    parameter  int NUM_ROWS = 8,
    localparam int XW  = bits_for(NUM_COLS - 1),
    localparam int YW  = bits_for(NUM_ROWS - 1),
    localparam int AW  = bits_for(NUM_ROWS),
    localparam int XMW = bits_for((NUM_COLS - 1) * NUM_ROWS),
    localparam int YMW = bits_for(NUM_ROWS * (NUM_ROWS - 1) / 2)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                frame_start,
    input  logic                row_valid,
    input  logic [YW-1:0]       row_idx,
    input  logic [NUM_COLS-1:0] pix_flags,
    input  logic [NUM_COLS-1:0] col_sel,
    output logic                rd_valid,
    output logic [AW-1:0]       rd_area,
    output logic [XMW-1:0]      rd_xmom,
    output logic [YMW-1:0]      rd_ymom
);

    logic acc_en, clr, rd_phase;

    logic [AW-1:0]  col_area [NUM_COLS];
    logic [XMW-1:0] col_xmom [NUM_COLS];
    logic [YMW-1:0] col_ymom [NUM_COLS];

    pma_seq #(.NY(NUM_ROWS)) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .frame_start(frame_start),
        .row_valid  (row_valid),
        .acc_en     (acc_en),
        .clr        (clr),
        .rd_phase   (rd_phase)
    );

    for (genvar c = 0; c < NUM_COLS; c++) begin : g_col
        pma_column #(
            .NY(NUM_ROWS), .XPOS(c), .XW(XW), .YW(YW),
            .AW(AW), .XMW(XMW), .YMW(YMW)
        ) u_col (
            .clk     (clk),
            .rst_n   (rst_n),
            .clr     (clr),
            .en      (acc_en),
            .oe      (rd_phase & col_sel[c]),
            .flag    (pix_flags[c]),
            .row_idx (row_idx),
            .area_drv(col_area[c]),
            .xmom_drv(col_xmom[c]),
            .ymom_drv(col_ymom[c])
        );
    end

    // Shared result bus: wired-OR of the per-column gated drivers.
    always_comb begin
        rd_area = '0;
        rd_xmom = '0;
        rd_ymom = '0;
        for (int c = 0; c < NUM_COLS; c++) begin
            rd_area = rd_area | col_area[c];
            rd_xmom = rd_xmom | col_xmom[c];
            rd_ymom = rd_ymom | col_ymom[c];
        end
    end

    assign rd_valid = rd_phase && (col_sel != '0);

    // R6
    sel_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(col_sel));

    // R7
    bus_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_valid |-> (rd_area == '0 && rd_xmom == '0 && rd_ymom == '0));

endmodule

// File: tb/pupil_moment_acc_bench.sv
module pupil_moment_acc_bench;

    localparam int NX  = 8;
    localparam int NY  = 8;
    localparam int YW  = 3;
    localparam int AW  = 4;
    localparam int XMW = 6;
    localparam int YMW = 5;

    // Row stimulus table, entry i fed as row i.
    localparam logic [NX-1:0] TAB [NY] = '{
        8'b0011_1100, 8'b0111_1110, 8'b1111_1111, 8'b1110_0111,
        8'b1000_0001, 8'b0000_0000, 8'b0101_1010, 8'b0001_1000
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic frame_start = 1'b0;
    logic row_valid = 1'b0;
    logic [YW-1:0] row_idx = '0;
    logic [NX-1:0] pix_flags = '0;
    logic [NX-1:0] col_sel = '0;
    logic rd_valid;
    logic [AW-1:0] rd_area;
    logic [XMW-1:0] rd_xmom;
    logic [YMW-1:0] rd_ymom;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    // Reference model state
    int m_area [NX];
    int m_x [NX];
    int m_y [NX];
    int m_cnt = 0;
    bit m_rows = 1'b0;
    bit m_hold = 1'b0;

    always #10 clk = ~clk;

    pupil_moment_acc #(.NUM_COLS(NX), .NUM_ROWS(NY)) u_pupil_moment_acc (
        .clk(clk), .rst_n(rst_n), .frame_start(frame_start),
        .row_valid(row_valid), .row_idx(row_idx), .pix_flags(pix_flags),
        .col_sel(col_sel), .rd_valid(rd_valid), .rd_area(rd_area),
        .rd_xmom(rd_xmom), .rd_ymom(rd_ymom)
    );

    task automatic chk(input string tag, input int got, input int exp);
        checks++;
        if (got != exp) begin
            errors++;
            $display("FAIL %s: got %0d expected %0d", tag, got, exp);
        end
    endtask

    task automatic model_clear();
        for (int c = 0; c < NX; c++) begin
            m_area[c] = 0; m_x[c] = 0; m_y[c] = 0;
        end
        m_cnt = 0;
    endtask

    // One clock cycle of stimulus, with the reference model updated per R2-R5.
    task automatic cycle(input bit fs, input bit rv, input int idx, input logic [NX-1:0] fl);
        @(negedge clk);
        frame_start = fs;
        row_valid   = rv;
        row_idx     = YW'(idx);
        pix_flags   = fl;
        @(posedge clk);
        if (fs) begin
            model_clear();
            m_rows = 1'b1;
            m_hold = 1'b0;
        end else if (rv && m_rows) begin
            for (int c = 0; c < NX; c++) begin
                if (fl[c]) begin
                    m_area[c] += 1; m_x[c] += c; m_y[c] += idx;
                end
            end
            m_cnt++;
            if (m_cnt == NY) begin
                m_rows = 1'b0;
                m_hold = 1'b1;
            end
        end
        @(negedge clk);
        frame_start = 1'b0;
        row_valid   = 1'b0;
        pix_flags   = '0;
    endtask

    task automatic read_col(input string tag, input int x);
        @(negedge clk);
        col_sel = NX'(1) << x;
        #5;
        if (m_hold) begin
            chk({tag, " R6 valid"}, int'(rd_valid), 1);
            chk({tag, " R3 area"}, int'(rd_area), m_area[x]);
            chk({tag, " R3 xmom"}, int'(rd_xmom), m_x[x]);
            chk({tag, " R3 ymom"}, int'(rd_ymom), m_y[x]);
        end else begin
            chk({tag, " R7 valid"}, int'(rd_valid), 0);
            chk({tag, " R7 area"}, int'(rd_area), 0);
            chk({tag, " R7 xmom"}, int'(rd_xmom), 0);
            chk({tag, " R7 ymom"}, int'(rd_ymom), 0);
        end
        col_sel = '0;
    endtask

    task automatic read_all(input string tag);
        for (int x = 0; x < NX; x++) read_col(tag, x);
    endtask

    initial begin
        #(20 * 200000);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog: got hung expected completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        model_clear();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state seen through the read bus
        @(negedge clk);
        col_sel = 8'b0000_0100;
        #5;
        chk("R1 valid after reset", int'(rd_valid), 0);
        chk("R1 area after reset", int'(rd_area), 0);
        chk("R1 xmom after reset", int'(rd_xmom), 0);
        chk("R1 ymom after reset", int'(rd_ymom), 0);
        col_sel = '0;

        // Frame A: table walk with idle gaps (R3, R4)
        cycle(1'b1, 1'b0, 0, '0);
        for (int i = 0; i < NY; i++) begin
            cycle(1'b0, 1'b1, i, TAB[i]);
            if (i == 3) begin
                read_col("R7 during rows", 2);
            end
            if (i % 2 == 1) begin
                cycle(1'b0, 1'b0, 7, 8'hFF);  // R4 idle cycle, flags ignored
            end
        end
        read_all("frameA");

        // R5: rows after the frame is complete are ignored
        cycle(1'b0, 1'b1, 7, 8'hFF);
        cycle(1'b0, 1'b1, 5, 8'hFF);
        read_col("R5 after extra rows", 0);
        read_col("R5 after extra rows", 7);

        // R7: nothing selected in hold
        @(negedge clk);
        col_sel = '0;
        #5;
        chk("R7 no select valid", int'(rd_valid), 0);
        chk("R7 no select area", int'(rd_area), 0);

        // Frame B: mid-frame restart with a coincident row (R2)
        cycle(1'b1, 1'b0, 0, '0);
        for (int i = 0; i < 3; i++) cycle(1'b0, 1'b1, i, 8'hFF);
        cycle(1'b1, 1'b1, 6, 8'hFF);  // R2 coincident row dropped
        for (int i = 0; i < NY; i++) begin
            cycle(1'b0, 1'b1, NY - 1 - i, ~TAB[i]);
        end
        read_all("R2 restart frameB");

        // Frame C: all ones, maximum sums (R8)
        cycle(1'b1, 1'b0, 0, '0);
        for (int i = 0; i < NY; i++) cycle(1'b0, 1'b1, i, 8'hFF);
        read_all("R8 all ones");
        read_col("R8 last column", NX - 1);
        chk("R8 model area max", m_area[NX-1], NY);
        chk("R8 model xmom max", m_x[NX-1], (NX - 1) * NY);
        chk("R8 model ymom max", m_y[0], NY * (NY - 1) / 2);

        // R2: frame_start from hold clears, bus quiet during rows
        cycle(1'b1, 1'b0, 0, '0);
        read_col("R2 cleared in rows", 4);

        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule